// File: doc/BRIEF.md
# Dithered Phase Accumulator for Direct Digital Synthesis

The block keeps a running phase word for a direct digital synthesizer. On every cycle with `in_valid` high it adds the unsigned `phase_step` to an internal accumulator. It then emits, one cycle later, the phase that held before the addition, with `out_valid` marking that sample. The phase word is `ADDR_W + 2 + FRAC_W` bits wide. The top two bits pick the quadrant, the next `ADDR_W` bits form a table address, and the low `FRAC_W` bits are the sub-address fraction. All arithmetic wraps modulo 2^phase width. The output frequency is the clock rate times the step divided by 2^phase width, and that ratio is also the frequency resolution. Choosing a step that stays below the Nyquist limit is the user's task.

With dithering enabled and a non-zero fraction, the block adds a pseudo-random offset to the accumulated phase after the accumulator register. The offset ranges over the fraction only, from zero to just under one address step, so the sum may or may not carry into the address. It comes from a maximal-length linear feedback shift register that steps once per valid sample. This spreads table-truncation error into broadband noise instead of discrete spurs. With dithering disabled, or a zero fraction, the phase passes through unchanged.

Top module: `dds_phase_dither`

## Requirements
- R1: While reset is asserted and until the first valid sample after it, `out_valid` is 0 and `phase_word` is 0. The accumulator restarts from `INIT_PHASE` (default 15'h1234) and the dither register restarts from its seed.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R3: On cycles with `in_valid` low, neither the accumulator nor the dither register advances, and `phase_word` holds its previous value.
- R4: The first valid sample after reset produces `INIT_PHASE` plus the dither value taken from the seed state.
- R5: Each valid sample adds `phase_step` to the accumulator modulo 2^15 (default `ADDR_W`=8, `FRAC_W`=5). The sample after a wrap shows the wrapped phase.
- R6: The dither register is `max(FRAC_W,3)` bits wide and is seeded with value 1. Each valid sample shifts it left, inserting the XOR of bits 4 and 2 (for the default width of 5). The offset is its low `FRAC_W` bits, taken before the shift.
- R7: The dither register never holds the all-zero state.
- R8: `phase_word` equals the accumulated phase plus the offset, modulo 2^phase width. The offset lies in 0 to 2^`FRAC_W`-1, and the sum carries into the address bits when the fraction overflows.
- R9: With `DITHER_EN`=0, `phase_word` equals the accumulated phase exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accept `phase_step` and advance this cycle |
| phase_step | input | ADDR_W+2+FRAC_W | Unsigned phase increment per sample |
| out_valid | output | 1 | `phase_word` carries a new sample |
| phase_word | output | ADDR_W+2+FRAC_W | Dithered phase: quadrant, address, fraction |

## Verification
A wrong accumulator value shows in the very next `phase_word` and stays offset in every later sample. Comparing each sample to a model therefore catches it within one valid cycle. A dither register with the wrong taps, the wrong seed or a wrong step rate changes only the low fraction bits and the occasional carry into the address. The bench compares every sample against its own model of the shift sequence, which exposes such a fault within a few samples. A non-dithered instance runs alongside, so a dither leaking into the plain path shows up as a direct mismatch.

// File: rtl/dds_phase_pkg.sv
package dds_phase_pkg;

  // Dither register length for a given fraction width.
  function automatic int unsigned dither_len(input int unsigned frac_w);
    return (frac_w < 3) ? 3 : frac_w;
  endfunction

  // Feedback tap mask (bit n-1 set for tap n) of a maximal-length sequence
  // for register lengths 3 to 32, shift-left form.
  function automatic logic [31:0] tap_mask(input int unsigned width);
    logic [31:0] m;
    case (width)
      3:  m = (32'd1 << 2)  | (32'd1 << 1);
      4:  m = (32'd1 << 3)  | (32'd1 << 2);
      5:  m = (32'd1 << 4)  | (32'd1 << 2);
      6:  m = (32'd1 << 5)  | (32'd1 << 4);
      7:  m = (32'd1 << 6)  | (32'd1 << 5);
      8:  m = (32'd1 << 7)  | (32'd1 << 5) | (32'd1 << 4) | (32'd1 << 3);
      9:  m = (32'd1 << 8)  | (32'd1 << 4);
      10: m = (32'd1 << 9)  | (32'd1 << 6);
      11: m = (32'd1 << 10) | (32'd1 << 8);
      12: m = (32'd1 << 11) | (32'd1 << 5) | (32'd1 << 3) | (32'd1 << 0);
      13: m = (32'd1 << 12) | (32'd1 << 3) | (32'd1 << 2) | (32'd1 << 0);
      14: m = (32'd1 << 13) | (32'd1 << 4) | (32'd1 << 2) | (32'd1 << 0);
      15: m = (32'd1 << 14) | (32'd1 << 13);
      16: m = (32'd1 << 15) | (32'd1 << 14) | (32'd1 << 12) | (32'd1 << 3);
      17: m = (32'd1 << 16) | (32'd1 << 13);
      18: m = (32'd1 << 17) | (32'd1 << 10);
      19: m = (32'd1 << 18) | (32'd1 << 5) | (32'd1 << 1) | (32'd1 << 0);
      20: m = (32'd1 << 19) | (32'd1 << 16);
      21: m = (32'd1 << 20) | (32'd1 << 18);
      22: m = (32'd1 << 21) | (32'd1 << 20);
      23: m = (32'd1 << 22) | (32'd1 << 17);
      24: m = (32'd1 << 23) | (32'd1 << 22) | (32'd1 << 21) | (32'd1 << 16);
      25: m = (32'd1 << 24) | (32'd1 << 21);
      26: m = (32'd1 << 25) | (32'd1 << 5) | (32'd1 << 1) | (32'd1 << 0);
      27: m = (32'd1 << 26) | (32'd1 << 4) | (32'd1 << 1) | (32'd1 << 0);
      28: m = (32'd1 << 27) | (32'd1 << 24);
      29: m = (32'd1 << 28) | (32'd1 << 26);
      30: m = (32'd1 << 29) | (32'd1 << 5) | (32'd1 << 3) | (32'd1 << 0);
      31: m = (32'd1 << 30) | (32'd1 << 27);
      default: m = (32'd1 << 31) | (32'd1 << 21) | (32'd1 << 1) | (32'd1 << 0);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dds_rst_sync.sv
module dds_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
  parameter int unsigned          PHASE_W    = 15,
  parameter logic [PHASE_W-1:0]   INIT_PHASE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] acc
);
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] acc_d;

  // Sum truncated to PHASE_W: natural modulo wrap.
  always_comb begin
    acc_d = acc_q;
    if (step_en) acc_d = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= INIT_PHASE;
    else if (step_en) acc_q <= acc_d;
  end

  assign acc = acc_q;

  p_acc_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(acc_q));

endmodule

// File: rtl/dds_dither_lfsr.sv
module dds_dither_lfsr
  import dds_phase_pkg::*;
#(
  parameter int unsigned  WIDTH = 5,
  parameter logic [WIDTH-1:0] SEED = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WIDTH-1:0] state
);
  localparam logic [31:0]      MASK32 = tap_mask(WIDTH);
  localparam logic [WIDTH-1:0] MASK   = MASK32[WIDTH-1:0];

  logic [WIDTH-1:0] st_q;
  logic [WIDTH-1:0] st_d;
  logic             fb;

  always_comb begin
    fb   = ^(st_q & MASK);
    st_d = st_q;
    if (adv) st_d = {st_q[WIDTH-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= SEED;
    else if (adv) st_q <= st_d;
  end

  assign state = st_q;

  p_never_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(st_q));

endmodule

// File: rtl/dds_dither_add.sv
module dds_dither_add #(
  parameter int unsigned PHASE_W = 15,
  parameter int unsigned FRAC_W  = 5,
  parameter bit          USE_DITHER = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [PHASE_W-1:0] acc,
  input  logic [((FRAC_W > 0) ? FRAC_W : 1)-1:0] offset,
  output logic               out_valid,
  output logic [PHASE_W-1:0] phase_word
);
  localparam int unsigned OFF_W = (FRAC_W > 0) ? FRAC_W : 1;
  localparam logic [PHASE_W:0] SPAN =
    USE_DITHER ? ((PHASE_W+1)'(1) << FRAC_W) : (PHASE_W+1)'(1);

  logic [PHASE_W-1:0] off_ext;
  logic [PHASE_W-1:0] sum_d;
  logic [PHASE_W-1:0] ph_q;
  logic               vld_q;

  generate
    if (USE_DITHER) begin : g_dith
      assign off_ext = PHASE_W'(offset);
    end else begin : g_plain
      logic unused_off;
      assign unused_off = ^offset;
      assign off_ext    = '0;
    end
  endgenerate

  always_comb begin
    sum_d = ph_q;
    if (smp_valid) sum_d = acc + off_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_valid;
      if (smp_valid) ph_q <= sum_d;
    end
  end

  assign out_valid  = vld_q;
  assign phase_word = ph_q;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(phase_word));
  p_offset_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, PHASE_W'(phase_word - $past(acc))} < SPAN));

endmodule

// File: rtl/dds_phase_dither.sv
module dds_phase_dither
  import dds_phase_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned FRAC_W    = 5,
  parameter bit          DITHER_EN = 1'b1,
  parameter logic [ADDR_W+2+FRAC_W-1:0] INIT_PHASE = 'h1234
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [ADDR_W+2+FRAC_W-1:0]   phase_step,
  output logic                         out_valid,
  output logic [ADDR_W+2+FRAC_W-1:0]   phase_word
);
  localparam int unsigned PHASE_W    = ADDR_W + 2 + FRAC_W;
  localparam bit          USE_DITHER = DITHER_EN && (FRAC_W > 0);
  localparam int unsigned LFSR_W     = dither_len(FRAC_W);
  localparam int unsigned OFF_W      = (FRAC_W > 0) ? FRAC_W : 1;

  logic               srst_n;
  logic [PHASE_W-1:0] acc;
  logic [OFF_W-1:0]   offset;

  dds_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dds_phase_accum #(.PHASE_W(PHASE_W), .INIT_PHASE(INIT_PHASE)) u_acc (
    .clk     (clk),
    .rst_n   (srst_n),
    .step_en (in_valid),
    .step    (phase_step),
    .acc     (acc)
  );

  generate
    if (USE_DITHER) begin : g_lfsr
      logic [LFSR_W-1:0] lfsr_state;
      dds_dither_lfsr #(.WIDTH(LFSR_W), .SEED(LFSR_W'(1))) u_lfsr (
        .clk   (clk),
        .rst_n (srst_n),
        .adv   (in_valid),
        .state (lfsr_state)
      );
      assign offset = lfsr_state[OFF_W-1:0];
    end else begin : g_nolfsr
      assign offset = '0;
    end
  endgenerate

  dds_dither_add #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W),
                   .USE_DITHER(USE_DITHER)) u_add (
    .clk        (clk),
    .rst_n      (srst_n),
    .smp_valid  (in_valid),
    .acc        (acc),
    .offset     (offset),
    .out_valid  (out_valid),
    .phase_word (phase_word)
  );

  // R1: nothing leaves the block while reset is held.
  p_reset_quiet_r1: assert property (@(posedge clk)
    !srst_n |=> (!out_valid && (phase_word == '0)));

endmodule

// File: tb/sim_dds_phase_dither.sv
`timescale 1ns/1ps
module sim_dds_phase_dither;
  localparam int unsigned PW = 15;
  localparam logic [PW-1:0] INIT = 15'h1234;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [PW-1:0] phase_step = '0;
  logic          ov0, ov1;
  logic [PW-1:0] pw0, pw1;

  always #10 clk = ~clk;

  dds_phase_dither #(.ADDR_W(8), .FRAC_W(5), .DITHER_EN(1'b1), .INIT_PHASE(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase_step(phase_step),
    .out_valid(ov0), .phase_word(pw0));

  dds_phase_dither #(.ADDR_W(8), .FRAC_W(5), .DITHER_EN(1'b0), .INIT_PHASE(INIT)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase_step(phase_step),
    .out_valid(ov1), .phase_word(pw1));

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;

  logic [PW-1:0] q0[$];
  logic [PW-1:0] q1[$];
  string         qt[$];

  logic [PW-1:0] acc_m;
  logic [4:0]    lfsr_m;
  logic [PW-1:0] last0, last1;
  bit            mon_en = 1'b0;

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    acc_m  = INIT;
    lfsr_m = 5'b00001;
    last0  = '0;
    last1  = '0;
    q0.delete(); q1.delete(); qt.delete();
  endtask

  // Driver: one valid sample, expected outputs queued.
  task automatic drive(input logic [PW-1:0] step, input string tag);
    @(negedge clk);
    in_valid   = 1'b1;
    phase_step = step;
    q0.push_back(acc_m + PW'(lfsr_m));  // R8/R6: offset from current state
    q1.push_back(acc_m);                // R9: plain path
    qt.push_back(tag);
    acc_m  = acc_m + step;              // R5
    lfsr_m = {lfsr_m[3:0], lfsr_m[4] ^ lfsr_m[2]};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid   = 1'b0;
      phase_step = 15'h5A5A;  // R3: garbage step ignored while idle
    end
  endtask

  // Monitor: samples a quarter period after the rising edge.
  always @(posedge clk) begin
    #5;
    if (mon_en) begin
      if (q0.size() != 0) begin
        string t;
        logic [PW-1:0] e0, e1;
        t  = qt.pop_front();
        e0 = q0.pop_front();
        e1 = q1.pop_front();
        check({"R2 valid ", t}, {14'd0, ov0}, 15'd1);
        check({t, " dithered"}, pw0, e0);
        check({"R9 ", t}, pw1, e1);
        last0 = pw0;
        last1 = pw1;
      end else begin
        check("R2 quiet", {14'd0, ov0}, 15'd0);
        check("R3 hold", pw0, last0);
        check("R3 hold plain", pw1, last1);
      end
    end
  end

  task automatic do_reset();
    mon_en = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {14'd0, ov0}, 15'd0);
    check("R1 reset phase", pw0, 15'd0);
    check("R1 reset phase plain", pw1, 15'd0);
    model_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    idle(2);                                  // R1: still zero before first sample
    drive(15'h0040, "R4 first sample");
    idle(3);
    for (int i = 0; i < 40; i++) drive(15'h0000, "R6 zero step");
    for (int i = 0; i < 20; i++) drive(15'h0001, "R8 carry unit step");
    for (int i = 0; i < 10; i++) begin
      drive(15'h13A7, "R5 large step");
      if (i % 3 == 0) idle(2);
    end
    for (int i = 0; i < 12; i++) drive(15'h7FFF, "R5 wrap near full");
    drive(15'h001F, "R8 fraction full");
    drive(15'h001F, "R8 fraction full");
    idle(4);
    do_reset();
    drive(15'h0100, "R4 after reset");
    for (int i = 0; i < 8; i++) drive(15'h4000, "R5 quadrant step");
    idle(3);
    mon_en = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule